// File: doc/BRIEF.md
# Zero-Turnaround Burst SRAM Core

This block is a synthesizable, cycle-accurate model of a synchronous SRAM. Reads and writes can follow each other on consecutive clocks with no idle cycle between them. A load cycle captures a base address, the operation type and the chip-select state. The following advance cycles step through a four-word burst. A mode pin chooses between a linear and an interleaved order for the two low address bits.

Reads are flow-through: after the edge, the addressed word is already on the output. Writes are pipelined. The byte-lane enables come with the address, and the write data follows at the next enabled edge. An inactive clock enable freezes the whole device for that edge. The array is a small parameterised register file with four 9-bit lanes per word.

Top module: `zbt_sram_core`

## Requirements
- R1: On a clock edge with `cke_ni` low and `adv_ld_i` low, the core captures `addr_i`, the operation, the select state and `ilv_i`, and the burst restarts at its first word.
- R2: On an enabled edge with `adv_ld_i` high and an active burst, the burst moves to its next word. `we_ni` is ignored on that edge.
- R3: The operation is fixed at load: `we_ni` low starts a write burst and `we_ni` high starts a read burst. A write burst never drives the output.
- R4: For burst step k (0..3) from base low bits b, the low two address bits are (b+k) mod 4 when `ilv_i`=0 was loaded, and b XOR k when `ilv_i`=1 was loaded. The upper address bits stay at their loaded value.
- R5: If advancing continues after the fourth word, the burst wraps back to its starting word.
- R6: An edge with `cke_ni` high has no effect: nothing is sampled, the burst does not move and no write commits.
- R7: On a write edge, bit n of `bw_ni` (low = enabled) is sampled together with the word address. At the next enabled edge, lane n of `data_i` (bits 9n+8..9n) is stored to that address. Lanes that were not enabled keep their contents.
- R8: The device is selected only when `ce_a_ni` is low, `ce_b_i` is high and `ce_c_ni` is low.
- R9: During an active read burst with `oe_ni` low, `data_oe_o` is high and `data_o` shows the stored word at the current burst address in the same cycle after the edge. Otherwise `data_oe_o` is low and `data_o` is zero.
- R10: A load with the device deselected starts no access. Later advances do nothing until a selected load occurs. A write still pending from the previous edge does commit.
- R11: After reset no burst is active, no write is pending, every word reads as zero and `data_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| adv_ld_i | input | 1 | High: advance the burst, low: load a new access |
| we_ni | input | 1 | Operation at load: low = write, high = read |
| ce_a_ni | input | 1 | Chip enable, active low |
| ce_b_i | input | 1 | Chip enable, active high |
| ce_c_ni | input | 1 | Chip enable, active low |
| bw_ni | input | LANES (4) | Byte-lane write enables, active low |
| oe_ni | input | 1 | Output enable, active low |
| ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | AW (4) | Word address |
| data_i | input | LANES*LANE_W (36) | Write data, one cycle after its address |
| data_o | output | LANES*LANE_W (36) | Read data, zero when not driven |
| data_oe_o | output | 1 | High when data_o carries read data |

## Verification
The commit of a pipelined write and the flow-through read of a new load can fall on the same edge. This happens when the last word of a write burst is followed directly by a read load of the same address. The bench provokes this case in both burst orders and with a partial lane mask. It expects the read to return the freshly merged word in that same cycle. A behavioural model applies the commit before the read lookup, and the bench compares against it on every clock, including stalled edges placed between a write and its data.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;

  // low address bits for burst step
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/zbt_burst_ctl.sv
`timescale 1ns/1ps
module zbt_burst_ctl
  import zbt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          ilv_i,
  input  logic [AW-1:0] addr_i,
  output logic          active_o,
  output logic [1:0]    step_o,
  output logic          rd_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          wr_start_o,
  output logic [AW-1:0] nxt_addr_o
);
  logic          act_q, act_d;
  op_e           op_q, op_d;
  logic          ilv_q, ilv_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    step_q, step_d;

  always_comb begin
    act_d  = act_q;
    op_d   = op_q;
    ilv_d  = ilv_q;
    base_d = base_q;
    step_d = step_q;
    if (en_i) begin
      if (load_i) begin
        act_d  = sel_i;
        op_d   = wr_i ? OP_WRITE : OP_READ;
        ilv_d  = ilv_i;
        base_d = addr_i;
        step_d = 2'd0;
      end else if (act_q) begin
        step_d = step_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      op_q   <= OP_READ;
      ilv_q  <= 1'b0;
      base_q <= '0;
      step_q <= 2'd0;
    end else begin
      act_q  <= act_d;
      op_q   <= op_d;
      ilv_q  <= ilv_d;
      base_q <= base_d;
      step_q <= step_d;
    end
  end

  assign active_o   = act_q;
  assign step_o     = step_q;
  assign rd_o       = act_q && (op_q == OP_READ);
  assign cur_addr_o = {base_q[AW-1:2], burst_low(base_q[1:0], step_q, ilv_q)};
  assign nxt_addr_o = {base_d[AW-1:2], burst_low(base_d[1:0], step_d, ilv_d)};
  assign wr_start_o = en_i && act_d && (op_d == OP_WRITE);
endmodule

// File: rtl/zbt_wr_pipe.sv
`timescale 1ns/1ps
module zbt_wr_pipe #(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] lane_we_o,
  output logic [AW-1:0]    waddr_o
);
  logic             pend_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
    end else if (en_i) begin
      pend_q <= start_i;
      addr_q <= addr_i;
      be_q   <= be_i;
    end
  end

  // data for a pending write lands on the next enabled edge
  assign lane_we_o = (en_i && pend_q) ? be_q : '0;
  assign waddr_o   = addr_q;
endmodule

// File: rtl/zbt_mem_array.sv
`timescale 1ns/1ps
module zbt_mem_array #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) lane_mem[w] <= '0;
      end else if (lane_we_i[l]) begin
        lane_mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/zbt_sram_core.sv
`timescale 1ns/1ps
module zbt_sram_core #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_ni,
  input  logic             adv_ld_i,
  input  logic             we_ni,
  input  logic             ce_a_ni,
  input  logic             ce_b_i,
  input  logic             ce_c_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             oe_ni,
  input  logic             ilv_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o,
  output logic             data_oe_o
);
  logic             en, sel;
  logic             active, rd_act, wr_start;
  logic [1:0]       burst_step;
  logic [AW-1:0]    cur_addr, nxt_addr, waddr;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    rdata;

  assign en  = ~cke_ni;
  assign sel = ~ce_a_ni & ce_b_i & ~ce_c_ni;

  zbt_burst_ctl #(.AW(AW)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .load_i     (~adv_ld_i),
    .sel_i      (sel),
    .wr_i       (~we_ni),
    .ilv_i      (ilv_i),
    .addr_i     (addr_i),
    .active_o   (active),
    .step_o     (burst_step),
    .rd_o       (rd_act),
    .cur_addr_o (cur_addr),
    .wr_start_o (wr_start),
    .nxt_addr_o (nxt_addr)
  );

  zbt_wr_pipe #(.AW(AW), .LANES(LANES)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .start_i   (wr_start),
    .addr_i    (nxt_addr),
    .be_i      (~bw_ni),
    .lane_we_o (lane_we),
    .waddr_o   (waddr)
  );

  zbt_mem_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lane_we_i (lane_we),
    .waddr_i   (waddr),
    .wdata_i   (data_i),
    .raddr_i   (cur_addr),
    .rdata_o   (rdata)
  );

  assign data_oe_o = rd_act & ~oe_ni;
  assign data_o    = data_oe_o ? rdata : '0;
endmodule

// File: rtl/zbt_sram_core_chk.sv
`timescale 1ns/1ps
module zbt_sram_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cke_ni,
  input logic       adv_ld_i,
  input logic       we_ni,
  input logic       ce_a_ni,
  input logic       ce_b_i,
  input logic       ce_c_ni,
  input logic       oe_ni,
  input logic       active,
  input logic [1:0] burst_step,
  input logic       data_oe_o
);
  logic sel_chk;
  assign sel_chk = !ce_a_ni && ce_b_i && !ce_c_ni;

  a_r1_load_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i) |=> (burst_step == 2'd0));

  a_r2_advance_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_ld_i && active) |=> (burst_step == $past(burst_step) + 2'd1) && active);

  a_r3_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && !we_ni) |=> !data_oe_o);

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_ld_i && active && burst_step == 2'd3) |=> (burst_step == 2'd0));

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(burst_step) && $stable(active)));

  a_r8_r10_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && !sel_chk) |=> (!active && !data_oe_o));

  a_r9_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);
endmodule

bind zbt_sram_core zbt_sram_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cke_ni     (cke_ni),
  .adv_ld_i   (adv_ld_i),
  .we_ni      (we_ni),
  .ce_a_ni    (ce_a_ni),
  .ce_b_i     (ce_b_i),
  .ce_c_ni    (ce_c_ni),
  .oe_ni      (oe_ni),
  .active     (active),
  .burst_step (burst_step),
  .data_oe_o  (data_oe_o)
);

// File: tb/tb_zbt_sram_core.sv
`timescale 1ns/1ps
module tb_zbt_sram_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_ni = 1'b0, adv_ld_i = 1'b1, we_ni = 1'b1;
  logic        ce_a_ni = 1'b0, ce_b_i = 1'b1, ce_c_ni = 1'b0;
  logic [3:0]  bw_ni = 4'hF;
  logic        oe_ni = 1'b0, ilv_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [35:0] data_i = '0;
  logic [35:0] data_o;
  logic        data_oe_o;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R11";

  zbt_sram_core dut (.*);

  always #2 clk_i = ~clk_i;

  // behavioural reference
  logic [35:0] m_mem [16];
  bit          m_act, m_wr, m_ilv, m_pend;
  int          m_base, m_cnt, m_paddr;
  logic [3:0]  m_pbe;

  function automatic int m_addr();
    int lo;
    lo = m_ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_mem[i]) m_mem[i] = '0;
      m_act = 0; m_wr = 0; m_ilv = 0; m_pend = 0;
      m_base = 0; m_cnt = 0; m_paddr = 0; m_pbe = '0;
    end else if (!cke_ni) begin
      if (m_pend)
        for (int l = 0; l < 4; l++)
          if (m_pbe[l]) m_mem[m_paddr][l*9 +: 9] = data_i[l*9 +: 9];
      if (!adv_ld_i) begin
        m_act  = !ce_a_ni && ce_b_i && !ce_c_ni;
        m_wr   = !we_ni;
        m_ilv  = ilv_i;
        m_base = int'(addr_i);
        m_cnt  = 0;
      end else if (m_act) begin
        m_cnt = (m_cnt + 1) % 4;
      end
      m_pend  = m_act && m_wr;
      m_paddr = m_addr();
      m_pbe   = ~bw_ni;
    end
  end

  task automatic compare();
    logic        exp_oe;
    logic [35:0] exp_d;
    exp_oe = m_act && !m_wr && !oe_ni;
    exp_d  = exp_oe ? m_mem[m_addr()] : 36'h0;
    checks++;
    if (data_oe_o !== exp_oe || data_o !== exp_d) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
               cur_req, data_oe_o, data_o, exp_oe, exp_d);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic cyc(input logic cke, input logic adv, input logic we,
                     input logic [3:0] bw, input logic [3:0] a, input logic [35:0] d);
    cke_ni = cke; adv_ld_i = adv; we_ni = we; bw_ni = bw; addr_i = a; data_i = d;
    @(negedge clk_i);
    compare();
  endtask

  function automatic logic [35:0] pat(input int k);
    return 36'h9_1234_5678 ^ (36'h1_0203_0405 * k) ^ {k[3:0], 32'h0};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cur_req = "R11";
    checks++;
    if (data_oe_o !== 1'b0) begin
      errors++;
      $display("FAIL R11: data_oe_o=%0b expected 0", data_oe_o);
    end
    cyc(0, 0, 1, 4'hF, 4'd7, 0);
    cyc(0, 1, 1, 4'hF, 4'd0, 0);

    // R1 R4 linear write burst from 5; R2 we_ni toggles while advancing
    cur_req = "R2";
    cyc(0, 0, 0, 4'h0, 4'd5, 0);
    cyc(0, 1, 1, 4'h0, 4'd0, pat(1));
    cyc(0, 1, 0, 4'h0, 4'd0, pat(2));
    cyc(0, 1, 1, 4'h0, 4'd0, pat(3));
    // R10 deselected load carries the last data
    cur_req = "R10";
    ce_b_i = 1'b0;
    cyc(0, 0, 1, 4'h0, 4'd0, pat(4));
    ce_b_i = 1'b1;
    cyc(0, 1, 0, 4'h0, 4'd1, pat(5));
    cyc(0, 1, 0, 4'h0, 4'd2, pat(6));

    // R4 R5 linear read burst with wrap
    cur_req = "R5";
    cyc(0, 0, 1, 4'hF, 4'd5, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 4'hF, 4'd0, 0);

    // R4 interleaved write from 9, then read load at same edge as last commit
    cur_req = "R4";
    ilv_i = 1'b1;
    cyc(0, 0, 0, 4'h0, 4'd9, 0);
    cyc(0, 1, 1, 4'h0, 4'd0, pat(7));
    cyc(0, 1, 1, 4'h0, 4'd0, pat(8));
    cyc(0, 1, 1, 4'h0, 4'd0, pat(9));
    cur_req = "R9";
    cyc(0, 0, 1, 4'hF, 4'd10, pat(10));
    cur_req = "R4";
    cyc(0, 0, 1, 4'hF, 4'd9, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 4'hF, 4'd0, 0);
    ilv_i = 1'b0;
    cyc(0, 0, 1, 4'hF, 4'd9, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 4'hF, 4'd0, 0);

    // R7 partial lanes: 0 and 2 enabled, read loaded on commit edge
    cur_req = "R7";
    cyc(0, 0, 0, 4'b1010, 4'd6, 0);
    cyc(0, 0, 1, 4'hF, 4'd6, 36'hF_FFFF_FFFF);
    cyc(0, 0, 0, 4'b0101, 4'd4, 0);
    cyc(0, 0, 1, 4'hF, 4'd4, 36'h0_0000_0000);

    // R6 stall between write and its data
    cur_req = "R6";
    cyc(0, 0, 0, 4'h0, 4'd12, 0);
    cyc(1, 0, 1, 4'hF, 4'd3, pat(20));
    cyc(1, 1, 0, 4'h3, 4'd1, pat(21));
    cyc(1, 0, 0, 4'h0, 4'd12, pat(22));
    cyc(0, 0, 1, 4'hF, 4'd12, pat(23));
    cyc(1, 1, 1, 4'hF, 4'd0, 0);
    cyc(1, 1, 1, 4'hF, 4'd0, 0);
    cyc(0, 1, 1, 4'hF, 4'd0, 0);

    // R3 write burst never drives output
    cur_req = "R3";
    cyc(0, 0, 0, 4'hF, 4'd14, 0);
    cyc(0, 1, 1, 4'hF, 4'd0, pat(30));

    // R9 output enable gating
    cur_req = "R9";
    oe_ni = 1'b1;
    cyc(0, 0, 1, 4'hF, 4'd5, 0);
    cyc(0, 1, 1, 4'hF, 4'd0, 0);
    oe_ni = 1'b0;
    cyc(0, 1, 1, 4'hF, 4'd0, 0);

    // R8 each enable deasserted in turn
    cur_req = "R8";
    ce_a_ni = 1'b1; cyc(0, 0, 1, 4'hF, 4'd5, 0); ce_a_ni = 1'b0;
    ce_b_i  = 1'b0; cyc(0, 0, 1, 4'hF, 4'd6, 0); ce_b_i  = 1'b1;
    ce_c_ni = 1'b1; cyc(0, 0, 1, 4'hF, 4'd9, 0); ce_c_ni = 1'b0;
    cyc(0, 1, 1, 4'hF, 4'd0, 0);
    ce_a_ni = 1'b1; cyc(0, 0, 0, 4'h0, 4'd7, 0);
    cyc(0, 1, 1, 4'h0, 4'd0, pat(40)); ce_a_ni = 1'b0;

    // R1 sweep of all words
    cur_req = "R1";
    for (int a = 0; a < 16; a++) cyc(0, 0, 1, 4'hF, 4'(a), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule